// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits on the received byte stream of a serial link, directly after the deserialiser. It looks at the destination address at the head of each frame and decides whether the station should keep that frame. The address is either one byte or two bytes long, as set by a configuration pin. It is compared against a programmed station address. A per-bit mask removes chosen bit positions from the comparison. With the mask the station can be made to take every frame, or only a group of addresses, such as multicast groups marked by the first address bit. An address made entirely of ones is a broadcast and is always accepted.

The byte stream goes through the block unchanged. Address bytes reach the downstream consumer whether the frame matches or not, so the host always sees the full address. Both stream sides use a valid/ready handshake. The block adds no storage on the stream path: `in_ready` is `out_ready`, and back-pressure from downstream stalls the upstream source in the same cycle. A byte counts as received only on a beat, which is a cycle where `in_valid` and `out_ready` are both high.

The decision is given as a one-cycle `addr_valid` strobe. `addr_match` carries the result and keeps it until the next frame starts.

Top module: `addr_filter`

## Requirements
- R1: `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready` in every cycle. Every byte is forwarded, address bytes included, whatever the decision. A byte is consumed only on a beat, where `in_valid` and `out_ready` are both 1.
- R2: With `cfg_wide`=1 the address is 16 bits. The first beat of the frame carries address bits 7:0 and the second beat carries bits 15:8. With a zero mask, the frame matches only when all 16 bits equal `cfg_station`.
- R3: With `cfg_wide`=0 the address is the first beat alone. Only bits 7:0 of `cfg_station` and `cfg_mask` take part, and bits 15:8 of both have no effect.
- R4: `addr_valid` is high for exactly one cycle: the cycle after the beat that completes the address. `addr_match` takes the new result on the same clock edge. Between decisions it changes only when a frame start clears it.
- R5: An all-ones address is accepted whatever the station address and mask. That is 16'hFFFF in 16-bit mode and 8'hFF in 8-bit mode.
- R6: A mask bit of 1 removes that address bit from the comparison. With every used mask bit set, every frame matches.
- R7: The first address bit received is bit 0 of the first beat. With station bit 0 set to 1 and all other used bits masked, the block accepts every address whose first bit is 1 and rejects every address whose first bit is 0, except the broadcast address.
- R8: A `frame_start` pulse clears `addr_match` and restarts address collection. A beat in the same cycle as `frame_start` is the first address byte of the new frame.
- R9: `frame_end` stops address collection. A beat in the same cycle as `frame_end` is still counted. If the address is not complete by then, no `addr_valid` is given, and later beats are ignored until the next `frame_start`.
- R10: Beats that follow a completed address in the same frame give no further decision, and `addr_match` holds its value.
- R11: After reset, `addr_valid` and `addr_match` are 0, and the block is collecting the first address byte without needing a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a received frame |
| frame_end | input | 1 | One-cycle pulse at the end of a received frame |
| cfg_wide | input | 1 | Address length: 1 = 16 bits, 0 = 8 bits |
| cfg_station | input | 16 | Programmed station address |
| cfg_mask | input | 16 | Per-bit comparison mask, 1 = bit ignored |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Upstream may advance; equals `out_ready` |
| in_data | input | 8 | Upstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Downstream byte |
| addr_valid | output | 1 | One-cycle strobe: an address decision is ready |
| addr_match | output | 1 | Decision for the current frame, 1 = keep |

## Verification
The bench targets the byte order of a two-byte address. A design that compares the bytes swapped accepts 16'h3412 when the station is 16'h1234. It also targets a `frame_start` that arrives with a beat in the same cycle. A design that drops that byte takes the wrong byte as the address, and a design that clears after the new decision loses the decision. Frames cut short before the address is complete must give no strobe, and a design that counts stalled cycles as beats gives early or false decisions once back-pressure is random. In 8-bit mode the bench sets station and mask bits above bit 7 to values that would flip the result. A design that does not gate those bits fails there, and the same applies to a broadcast check that tests all 16 bits.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int BYTE_W_DEF = 8;

  typedef enum logic [1:0] {
    SEQ_LO   = 2'd0,
    SEQ_HI   = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/addr_filter_seq.sv
module addr_filter_seq
  import addr_filter_pkg::*;
#(
  parameter int BW = BYTE_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            frame_end,
  input  logic            beat,
  input  logic            wide,
  input  logic [BW-1:0]   byte_in,
  output logic            fire,
  output logic [2*BW-1:0] full_addr
);
  seq_state_t st_q, st_base, st_d;
  logic [BW-1:0] lo_q;

  // A start pulse restarts collection in the same cycle, so a beat
  // arriving with it is taken as the first address byte.
  always_comb begin
    st_base = frame_start ? SEQ_LO : st_q;
    st_d    = st_base;
    fire    = 1'b0;
    if (beat) begin
      case (st_base)
        SEQ_LO: begin
          if (wide) begin
            st_d = SEQ_HI;
          end else begin
            st_d = SEQ_DONE;
            fire = 1'b1;
          end
        end
        SEQ_HI: begin
          st_d = SEQ_DONE;
          fire = 1'b1;
        end
        default: ;
      endcase
    end
    if (frame_end) st_d = SEQ_DONE;
  end

  assign full_addr = (st_base == SEQ_HI) ? {byte_in, lo_q} : {{BW{1'b0}}, byte_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SEQ_LO;
      lo_q <= '0;
    end else begin
      st_q <= st_d;
      if (beat && st_base == SEQ_LO) lo_q <= byte_in;
    end
  end
endmodule

// File: rtl/addr_filter_cmp.sv
module addr_filter_cmp #(
  parameter int BW = 8
) (
  input  logic [2*BW-1:0] addr,
  input  logic [2*BW-1:0] station,
  input  logic [2*BW-1:0] mask,
  input  logic            wide,
  output logic            hit
);
  localparam int AW = 2 * BW;

  logic [AW-1:0] agree;
  logic          bcast;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < BW) begin : g_low
      assign agree[i] = mask[i] | ~(addr[i] ^ station[i]);
    end else begin : g_high
      // Upper bits drop out of the comparison in single-byte mode.
      assign agree[i] = ~wide | mask[i] | ~(addr[i] ^ station[i]);
    end
  end

  assign bcast = wide ? (&addr) : (&addr[BW-1:0]);
  assign hit   = bcast | (&agree);
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF,
  localparam int AW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              cfg_wide,
  input  logic [AW-1:0]     cfg_station,
  input  logic [AW-1:0]     cfg_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              addr_valid,
  output logic              addr_match
);
  logic          beat;
  logic          dec_fire;
  logic [AW-1:0] full_addr;
  logic          hit;

  // Stream passes straight through; the filter only observes beats.
  assign out_valid = in_valid;
  assign out_data  = in_data;
  assign in_ready  = out_ready;
  assign beat      = in_valid & out_ready;

  addr_filter_seq #(.BW(BYTE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .beat        (beat),
    .wide        (cfg_wide),
    .byte_in     (in_data),
    .fire        (dec_fire),
    .full_addr   (full_addr)
  );

  addr_filter_cmp #(.BW(BYTE_W)) u_cmp (
    .addr    (full_addr),
    .station (cfg_station),
    .mask    (cfg_mask),
    .wide    (cfg_wide),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_match <= 1'b0;
    end else begin
      addr_valid <= dec_fire;
      if (dec_fire)         addr_match <= hit;
      else if (frame_start) addr_match <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
  parameter int BYTE_W = 8,
  localparam int AW    = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              cfg_wide,
  input logic [AW-1:0]     cfg_mask,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              addr_valid,
  input logic              addr_match,
  input logic              dec_fire,
  input logic [AW-1:0]     full_addr
);
  AST_STREAM_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (out_data == in_data) && (in_ready == out_ready)); // R1

  AST_STROBE_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(dec_fire)); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_fire && !frame_start) |=> $stable(addr_match)); // R4

  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && (cfg_wide ? (&full_addr) : (&full_addr[BYTE_W-1:0])))
      |=> (addr_valid && addr_match)); // R5

  AST_FULL_MASK_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && (cfg_wide ? (&cfg_mask) : (&cfg_mask[BYTE_W-1:0])))
      |=> addr_match); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !dec_fire) |=> (!addr_match && !addr_valid)); // R8
endmodule

bind addr_filter addr_filter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .cfg_wide    (cfg_wide),
  .cfg_mask    (cfg_mask),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .addr_valid  (addr_valid),
  .addr_match  (addr_match),
  .dec_fire    (dec_fire),
  .full_addr   (full_addr)
);

// File: tb/addr_filter_tb.sv
module addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        frame_end = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [15:0] cfg_station = '0;
  logic [15:0] cfg_mask = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        addr_valid;
  logic        addr_match;

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;

  always #5 clk = ~clk;

  addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .cfg_wide(cfg_wide), .cfg_station(cfg_station), .cfg_mask(cfg_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .addr_valid(addr_valid), .addr_match(addr_match)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  byte unsigned m_q[$];
  bit   m_open = 1'b1;
  logic exp_valid = 1'b0;
  logic exp_match = 1'b0;
  bit   m_fire;
  bit   m_hit;
  int   m_addr;
  int   m_wm;

  always @(posedge clk) begin
    m_fire = 1'b0;
    m_hit  = 1'b0;
    if (!rst_n) begin
      m_q.delete();
      m_open = 1'b1;
      exp_valid <= 1'b0;
      exp_match <= 1'b0;
    end else begin
      if (frame_start) begin
        m_q.delete();
        m_open = 1'b1;
      end
      if (in_valid && out_ready && m_open) begin
        m_q.push_back(in_data);
        if (m_q.size() == (cfg_wide ? 2 : 1)) begin
          m_addr = cfg_wide ? ((int'(m_q[1]) << 8) | int'(m_q[0])) : int'(m_q[0]);
          m_wm   = cfg_wide ? 'hFFFF : 'hFF;
          m_hit  = ((m_addr & m_wm) == m_wm) ||
                   (((m_addr ^ int'(cfg_station)) & ~int'(cfg_mask) & m_wm) == 0);
          m_fire = 1'b1;
          m_open = 1'b0;
        end
      end
      if (frame_end) m_open = 1'b0;
      exp_valid <= m_fire;
      exp_match <= m_fire ? m_hit : (frame_start ? 1'b0 : exp_match);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(addr_valid === exp_valid, "R4", "addr_valid vs model", 32'(addr_valid), 32'(exp_valid));
      check(addr_match === exp_match, "R4", "addr_match vs model", 32'(addr_match), 32'(exp_match));
      check(out_valid === in_valid && out_data === in_data && in_ready === out_ready,
            "R1", "stream pass-through", {out_valid, out_data, in_ready},
            {in_valid, in_data, out_ready});
    end
  end

  always @(negedge clk) out_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(posedge clk);
      if (out_ready) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pulse_end();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  function automatic bit ref_hit(input bit wide, input logic [15:0] st,
                                 input logic [15:0] mk, input logic [15:0] a);
    logic [15:0] wm;
    wm = wide ? 16'hFFFF : 16'h00FF;
    return ((a & wm) == wm) || (((a ^ st) & ~mk & wm) == 16'h0);
  endfunction

  task automatic run_frame(input bit wide, input logic [15:0] st, input logic [15:0] mk,
                           input logic [15:0] a, input bit exp, input string req);
    cfg_wide = wide;
    cfg_station = st;
    cfg_mask = mk;
    pulse_start();
    put_byte(a[7:0]);
    if (wide) put_byte(a[15:8]);
    check(addr_valid === 1'b1 && addr_match === exp, req, "decision",
          {addr_valid, addr_match}, {1'b1, exp});
    put_byte(8'h5A);
    put_byte(8'hC3);
    check(addr_match === exp, "R10", "decision held over payload", 32'(addr_match), 32'(exp));
    pulse_end();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state and ready for first byte without a start pulse
    check(addr_valid === 1'b0 && addr_match === 1'b0, "R11", "reset outputs",
          {addr_valid, addr_match}, 0);
    cfg_wide = 1'b0; cfg_station = 16'h0042; cfg_mask = 16'h0;
    put_byte(8'h42);
    check(addr_valid === 1'b1 && addr_match === 1'b1, "R11", "first frame after reset",
          {addr_valid, addr_match}, 2'b11);
    pulse_end();

    // R2: two-byte order and exact match
    run_frame(1'b1, 16'h1234, 16'h0000, 16'h1234, 1'b1, "R2");
    run_frame(1'b1, 16'h1234, 16'h0000, 16'h3412, 1'b0, "R2");
    run_frame(1'b1, 16'h1234, 16'h0000, 16'h1235, 1'b0, "R2");
    // R3: single-byte mode ignores upper station and mask bits
    run_frame(1'b0, 16'h9977, 16'h0000, 16'h0077, 1'b1, "R3");
    run_frame(1'b0, 16'h0077, 16'hFF00, 16'h0076, 1'b0, "R3");
    // R5: broadcast
    run_frame(1'b1, 16'h1234, 16'h0000, 16'hFFFF, 1'b1, "R5");
    run_frame(1'b0, 16'h1234, 16'h0000, 16'h00FF, 1'b1, "R5");
    run_frame(1'b1, 16'h1234, 16'h0000, 16'h00FF, 1'b0, "R5");
    // R6: masking
    run_frame(1'b1, 16'h0000, 16'hFFFF, 16'hBEEF, 1'b1, "R6");
    run_frame(1'b0, 16'h0000, 16'h00FF, 16'h0013, 1'b1, "R6");
    run_frame(1'b1, 16'h1230, 16'h000F, 16'h123C, 1'b1, "R6");
    run_frame(1'b1, 16'h1230, 16'h000F, 16'h133C, 1'b0, "R6");
    // R7: multicast group by first address bit
    run_frame(1'b1, 16'h0001, 16'hFFFE, 16'h4401, 1'b1, "R7");
    run_frame(1'b1, 16'h0001, 16'hFFFE, 16'h4400, 1'b0, "R7");
    run_frame(1'b0, 16'h0001, 16'h00FE, 16'h0081, 1'b1, "R7");

    // R8: start pulse alone clears a held match
    run_frame(1'b0, 16'h0010, 16'h0000, 16'h0010, 1'b1, "R8");
    pulse_start();
    check(addr_match === 1'b0, "R8", "start clears match", 32'(addr_match), 0);
    // R8: byte in same cycle as start is the first address byte
    run_frame(1'b0, 16'h0020, 16'h0000, 16'h0020, 1'b1, "R8");
    repeat (2) @(negedge clk);
    frame_start = 1'b1; in_valid = 1'b1; in_data = 8'h21;
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
    check(addr_valid === 1'b1 && addr_match === 1'b0, "R8", "same-cycle start and byte",
          {addr_valid, addr_match}, 2'b10);
    frame_start = 1'b1; in_valid = 1'b1; in_data = 8'h20;
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
    check(addr_valid === 1'b1 && addr_match === 1'b1, "R8", "same-cycle start then match",
          {addr_valid, addr_match}, 2'b11);

    // R9: frame ends before the address is complete
    cfg_wide = 1'b1; cfg_station = 16'hAA55; cfg_mask = 16'h0;
    pulse_start();
    put_byte(8'h55);
    pulse_end();
    put_byte(8'hAA);
    check(addr_valid === 1'b0 && addr_match === 1'b0, "R9", "no decision after early end",
          {addr_valid, addr_match}, 0);
    put_byte(8'h55);
    put_byte(8'hAA);
    check(addr_valid === 1'b0 && addr_match === 1'b0, "R9", "beats ignored until start",
          {addr_valid, addr_match}, 0);
    // R9: beat in the same cycle as end still completes the address
    pulse_start();
    put_byte(8'h55);
    frame_end = 1'b1; in_valid = 1'b1; in_data = 8'hAA;
    @(negedge clk);
    frame_end = 1'b0; in_valid = 1'b0;
    check(addr_valid === 1'b1 && addr_match === 1'b1, "R9", "byte with end counted",
          {addr_valid, addr_match}, 2'b11);

    // R1 and all: random frames under random back-pressure
    stall_en = 1'b1;
    for (int n = 0; n < 60; n++) begin
      logic [15:0] st, mk, a;
      bit w;
      w  = 1'($urandom);
      st = 16'($urandom);
      mk = (($urandom % 3) == 0) ? 16'($urandom) : 16'h0;
      a  = (($urandom % 2) == 0) ? (st ^ (16'($urandom) & 16'h0101)) : 16'($urandom);
      if (($urandom % 8) == 0) a = 16'hFFFF;
      run_frame(w, st, mk, a, ref_hit(w, st, mk, a), "R1");
    end
    stall_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule